// File: doc/BRIEF.md
# Flag-Based Magnitude Comparator

This combinational unit compares two N-bit operands by subtracting them once and reading the outcome from four condition flags. The difference is formed by an adder as the first operand plus the bitwise inverse of the second plus one. The adder's raw carry-out is kept with no-borrow meaning. Zero, sign and two's complement overflow are taken from the same result.

All six relations are then decoded from those four flags alone: equal, not equal, greater-or-equal, greater, less-or-equal and less. Each relation is given for a signed reading and for an unsigned reading. A third relation vector follows a select input and repeats whichever reading it names. There is no register, so every output settles in the same cycle as its inputs.

Top module: `cmp_flag_unit`

## Requirements
- R1: `diff_o` equals `a_i - b_i` modulo 2^N.
- R2: The carry flag (`flags_o[3]`) is 1 exactly when `a_i >= b_i` read as unsigned values. A value of 1 means no borrow.
- R3: The zero flag (`flags_o[0]`) is 1 exactly when `a_i == b_i`.
- R4: The sign flag (`flags_o[2]`) equals the top bit of `diff_o`.
- R5: The overflow flag (`flags_o[1]`) is 1 exactly when the operand top bits differ and the top bit of the difference differs from that of `a_i`.
- R6: In every relation vector, bit 0 is equal (the zero flag) and bit 1 is not-equal (its inverse).
- R7: In `rel_signed_o`, bit 2 (greater-or-equal) is 1 when sign XOR overflow is 0, and bit 5 (less) is that XOR itself.
- R8: In `rel_signed_o`, bit 3 (greater) is 1 when (sign XOR overflow) OR zero is 0, and bit 4 (less-or-equal) is its inverse.
- R9: In `rel_unsigned_o`, bit 2 (greater-or-equal) is the carry and bit 5 (less) its inverse. Bit 3 (greater) is carry AND NOT zero, and bit 4 (less-or-equal) its inverse.
- R10: `rel_sel_o` equals `rel_signed_o` when `signed_i` is 1 and `rel_unsigned_o` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand (minuend) |
| b_i | input | N | Second operand (subtrahend) |
| signed_i | input | 1 | Picks the signed reading for rel_sel_o when 1 |
| diff_o | output | N | Difference a_i - b_i |
| flags_o | output | 4 | {carry, sign, overflow, zero} |
| rel_signed_o | output | 6 | {lt, le, gt, ge, ne, eq}, signed reading |
| rel_unsigned_o | output | 6 | {lt, le, gt, ge, ne, eq}, unsigned reading |
| rel_sel_o | output | 6 | Relation vector chosen by signed_i |

## Verification
The bench builds two copies of the unit. The first uses N=8, which brings the whole operand space within reach: all 65536 operand pairs are compared against the language's own signed and unsigned operators. A short table of hand-worked vectors pins the exact flag codes at zero, the largest positive value, the most negative value and all ones. The second copy uses the default N=32 and is driven with the same corner values at full width plus a set of scattered patterns. There it confirms that the carry chain and the overflow rule scale beyond the exhaustively covered width.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // flag vector layout
  localparam int FL_ZERO  = 0;
  localparam int FL_OVF   = 1;
  localparam int FL_SIGN  = 2;
  localparam int FL_CARRY = 3;
  localparam int FL_W     = 4;

  // relation vector layout
  localparam int RL_EQ = 0;
  localparam int RL_NE = 1;
  localparam int RL_GE = 2;
  localparam int RL_GT = 3;
  localparam int RL_LE = 4;
  localparam int RL_LT = 5;
  localparam int RL_W  = 6;

  typedef struct packed {
    logic carry;
    logic sign;
    logic ovf;
    logic zero;
  } flags_t;

  // one-bit full adder, used bit by bit in the subtractor
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic cin);
    logic s, co;
    s  = x ^ y ^ cin;
    co = (x & y) | (x & cin) | (y & cin);
    return {co, s};
  endfunction

  // signed relations from flags
  function automatic logic [RL_W-1:0] rel_from_flags_signed(input flags_t f);
    logic [RL_W-1:0] r;
    logic less;
    less      = f.sign ^ f.ovf;
    r[RL_EQ]  = f.zero;
    r[RL_NE]  = ~f.zero;
    r[RL_GE]  = ~less;
    r[RL_LT]  = less;
    r[RL_GT]  = ~(less | f.zero);
    r[RL_LE]  = less | f.zero;
    return r;
  endfunction

  // unsigned relations from flags, carry = no borrow
  function automatic logic [RL_W-1:0] rel_from_flags_unsigned(input flags_t f);
    logic [RL_W-1:0] r;
    logic above;
    above     = f.carry & ~f.zero;
    r[RL_EQ]  = f.zero;
    r[RL_NE]  = ~f.zero;
    r[RL_GE]  = f.carry;
    r[RL_LT]  = ~f.carry;
    r[RL_GT]  = above;
    r[RL_LE]  = ~above;
    return r;
  endfunction

endpackage

// File: rtl/cmp_subtractor.sv
module cmp_subtractor #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] diff_o,
  output logic         carry_out_o,
  output logic         carry_msb_in_o
);
  import cmp_pkg::*;

  logic [N-1:0] b_inv;
  logic [N:0]   chain;

  assign b_inv    = ~b_i;
  assign chain[0] = 1'b1;  // the +1 of the two's complement

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] fa;
    assign fa          = full_add(a_i[i], b_inv[i], chain[i]);
    assign diff_o[i]   = fa[0];
    assign chain[i+1]  = fa[1];
  end

  assign carry_out_o    = chain[N];
  assign carry_msb_in_o = chain[N-1];
endmodule

// File: rtl/cmp_flag_gen.sv
module cmp_flag_gen #(
  parameter int N = 32
) (
  input  logic [N-1:0]         diff_i,
  input  logic                 carry_out_i,
  input  logic                 carry_msb_in_i,
  output cmp_pkg::flags_t      flags_o
);
  always_comb begin
    flags_o.zero  = (diff_i == '0);
    flags_o.sign  = diff_i[N-1];
    flags_o.carry = carry_out_i;
    // carry into the top bit disagreeing with carry out of it
    flags_o.ovf   = carry_out_i ^ carry_msb_in_i;
  end
endmodule

// File: rtl/cmp_rel_decode.sv
module cmp_rel_decode #(
  parameter bit IS_SIGNED = 1'b1
) (
  input  cmp_pkg::flags_t              flags_i,
  output logic [cmp_pkg::RL_W-1:0]     rel_o
);
  import cmp_pkg::*;

  if (IS_SIGNED) begin : g_signed
    assign rel_o = rel_from_flags_signed(flags_i);
  end else begin : g_unsigned
    assign rel_o = rel_from_flags_unsigned(flags_i);
  end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         signed_i,
  output logic [N-1:0] diff_o,
  output logic [3:0]   flags_o,
  output logic [5:0]   rel_signed_o,
  output logic [5:0]   rel_unsigned_o,
  output logic [5:0]   rel_sel_o
);
  import cmp_pkg::*;

  logic            carry_out;
  logic            carry_msb_in;
  flags_t          flags;
  logic [RL_W-1:0] rel_s;
  logic [RL_W-1:0] rel_u;

  cmp_subtractor #(.N(N)) u_sub (
    .a_i            (a_i),
    .b_i            (b_i),
    .diff_o         (diff_o),
    .carry_out_o    (carry_out),
    .carry_msb_in_o (carry_msb_in)
  );

  cmp_flag_gen #(.N(N)) u_flags (
    .diff_i         (diff_o),
    .carry_out_i    (carry_out),
    .carry_msb_in_i (carry_msb_in),
    .flags_o        (flags)
  );

  cmp_rel_decode #(.IS_SIGNED(1'b1)) u_dec_s (
    .flags_i (flags),
    .rel_o   (rel_s)
  );

  cmp_rel_decode #(.IS_SIGNED(1'b0)) u_dec_u (
    .flags_i (flags),
    .rel_o   (rel_u)
  );

  assign flags_o        = flags;
  assign rel_signed_o   = rel_s;
  assign rel_unsigned_o = rel_u;
  assign rel_sel_o      = signed_i ? rel_s : rel_u;
endmodule

// File: rtl/cmp_flag_unit_chk.sv
module cmp_flag_unit_chk #(
  parameter int N = 32
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         signed_i,
  input logic [N-1:0] diff_o,
  input logic [3:0]   flags_o,
  input logic [5:0]   rel_signed_o,
  input logic [5:0]   rel_unsigned_o,
  input logic [5:0]   rel_sel_o
);
  always_comb begin
    // R5
    no_overflow_chk: assert (flags_o[1] ==
      ((a_i[N-1] != b_i[N-1]) && (diff_o[N-1] != a_i[N-1])));
    // R3
    zero_equal_chk: assert (flags_o[0] == (a_i == b_i));
    // R2
    carry_noborrow_chk: assert (flags_o[3] == (a_i >= b_i));
    // R6
    eq_ne_excl_chk: assert ((rel_signed_o[0] ^ rel_signed_o[1]) &&
                            (rel_unsigned_o[0] ^ rel_unsigned_o[1]));
    // R7
    signed_ge_lt_chk: assert (rel_signed_o[2] != rel_signed_o[5]);
    // R10
    sel_follow_chk: assert (rel_sel_o == (signed_i ? rel_signed_o : rel_unsigned_o));
  end
endmodule

bind cmp_flag_unit cmp_flag_unit_chk #(.N(N)) u_chk (
  .a_i            (a_i),
  .b_i            (b_i),
  .signed_i       (signed_i),
  .diff_o         (diff_o),
  .flags_o        (flags_o),
  .rel_signed_o   (rel_signed_o),
  .rel_unsigned_o (rel_unsigned_o),
  .rel_sel_o      (rel_sel_o)
);

// File: tb/cmp_flag_unit_bench.sv
module cmp_flag_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NW = 32;
  localparam int NVEC = 8;

  // {a, b, flags{carry,sign,ovf,zero}, rel_signed, rel_unsigned}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 4'b1001, 6'b010101, 6'b010101},
    {8'h7F, 8'h80, 4'b0110, 6'b001110, 6'b110010},
    {8'h80, 8'h7F, 4'b1010, 6'b110010, 6'b001110},
    {8'hFF, 8'h00, 4'b1100, 6'b110010, 6'b001110},
    {8'h00, 8'hFF, 4'b0000, 6'b001110, 6'b110010},
    {8'h80, 8'h80, 4'b1001, 6'b010101, 6'b010101},
    {8'h01, 8'h02, 4'b0100, 6'b110010, 6'b110010},
    {8'h80, 8'h01, 4'b1010, 6'b110010, 6'b001110}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  logic [NS-1:0] a8, b8;
  logic          sg8;
  logic [NS-1:0] d8;
  logic [3:0]    f8;
  logic [5:0]    rs8, ru8, rsel8;

  logic [NW-1:0] a32, b32;
  logic          sg32;
  logic [NW-1:0] d32;
  logic [3:0]    f32;
  logic [5:0]    rs32, ru32, rsel32;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_flag_unit #(.N(NS)) u_cmp_flag_unit (
    .a_i(a8), .b_i(b8), .signed_i(sg8), .diff_o(d8), .flags_o(f8),
    .rel_signed_o(rs8), .rel_unsigned_o(ru8), .rel_sel_o(rsel8)
  );

  cmp_flag_unit #(.N(NW)) u_cmp_flag_unit_w (
    .a_i(a32), .b_i(b32), .signed_i(sg32), .diff_o(d32), .flags_o(f32),
    .rel_signed_o(rs32), .rel_unsigned_o(ru32), .rel_sel_o(rsel32)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {lt, le, gt, ge, ne, eq}
  function automatic logic [5:0] rel_vec(input logic lt, input logic eq);
    return {lt, lt | eq, ~(lt | eq), ~lt, ~eq, eq};
  endfunction

  task automatic check_wide(input logic [NW-1:0] a, input logic [NW-1:0] b);
    logic [NW-1:0] d;
    logic ovf;
    a32 = a; b32 = b; sg32 = 1'b1;
    #1;
    d   = a - b;
    ovf = (a[NW-1] != b[NW-1]) && (d[NW-1] != a[NW-1]);
    check("R1 wide diff", 64'(d32), 64'(d));
    check("R2 R3 R4 R5 wide flags", 64'(f32), 64'({a >= b, d[NW-1], ovf, a == b}));
    check("R6 R7 R8 wide signed", 64'(rs32), 64'(rel_vec($signed(a) < $signed(b), a == b)));
    check("R9 wide unsigned", 64'(ru32), 64'(rel_vec(a < b, a == b)));
    check("R10 wide sel signed", 64'(rsel32), 64'(rs32));
    sg32 = 1'b0;
    #1;
    check("R10 wide sel unsigned", 64'(rsel32), 64'(ru32));
  endtask

  initial begin
    a8 = '0; b8 = '0; sg8 = 1'b0;
    a32 = '0; b32 = '0; sg32 = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // initial state with zero operands
    check("R3 reset zero flag", 64'(f8), 64'(4'b1001));
    check("R6 reset rel_sel", 64'(rsel8), 64'(6'b010101));

    // table of worked vectors
    for (int i = 0; i < NVEC; i++) begin
      a8 = VEC[i][31:24]; b8 = VEC[i][23:16]; sg8 = 1'b1;
      #1;
      check("R2 R3 R4 R5 table flags", 64'(f8), 64'(VEC[i][15:12]));
      check("R7 R8 table signed", 64'(rs8), 64'(VEC[i][11:6]));
      check("R9 table unsigned", 64'(ru8), 64'(VEC[i][5:0]));
      check("R10 table sel signed", 64'(rsel8), 64'(VEC[i][11:6]));
      sg8 = 1'b0;
      #1;
      check("R10 table sel unsigned", 64'(rsel8), 64'(VEC[i][5:0]));
    end

    // exhaustive 8-bit sweep against native operators
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        logic [NS-1:0] ea, eb, ed;
        ea = NS'(ia); eb = NS'(ib);
        a8 = ea; b8 = eb; sg8 = ib[0];
        #1;
        ed = ea - eb;
        check("R1 diff", 64'(d8), 64'(ed));
        check("R2 carry", 64'(f8[3]), 64'(ea >= eb));
        check("R3 zero", 64'(f8[0]), 64'(ea == eb));
        check("R4 sign", 64'(f8[2]), 64'(ed[NS-1]));
        check("R5 ovf", 64'(f8[1]),
              64'((ea[NS-1] != eb[NS-1]) && (ed[NS-1] != ea[NS-1])));
        check("R6 R7 R8 signed rels", 64'(rs8),
              64'(rel_vec($signed(ea) < $signed(eb), ea == eb)));
        check("R9 unsigned rels", 64'(ru8), 64'(rel_vec(ea < eb, ea == eb)));
        check("R10 sel", 64'(rsel8), 64'(ib[0] ? rs8 : ru8));
      end
      @(negedge clk);
    end

    // full width corners and scattered patterns
    check_wide(32'h0000_0000, 32'h0000_0000);
    check_wide(32'h7FFF_FFFF, 32'h8000_0000);
    check_wide(32'h8000_0000, 32'h7FFF_FFFF);
    check_wide(32'hFFFF_FFFF, 32'h0000_0000);
    check_wide(32'h0000_0000, 32'hFFFF_FFFF);
    check_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check_wide(32'h8000_0000, 32'h0000_0001);
    check_wide(32'h1234_5678, 32'h1234_5679);
    check_wide(32'hDEAD_BEEF, 32'h0BAD_F00D);
    check_wide(32'h7FFF_FFFF, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule